// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is a 16-bit up-counter that never stops. It advances on the bus clock after a power-of-two divider. Software reaches it through a byte-wide register port with a 2-bit address. The counter is read as two separate bytes. It can also be written one byte at a time, and the other byte keeps its value.

A control byte holds the divider select and the wrap-interrupt enable. A status byte holds the wrap flag. The flag is set each time the counter rolls from its top value back to zero. An interrupt line is high while the flag and the enable are both set.

The divider select can be changed only during a short window after reset. After that, writes to the control byte still update every other bit, but the select bits keep their value.

Top module: `frc_timer`

## Requirements
- R1: The counter advances once every N bus cycles. N is chosen by control bits [1:0]: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. The divider phase runs freely from reset, and a tick falls on the cycles where the low log2(N) bits of the bus-cycle count since reset are all ones.
- R2: Control bits [1:0] take a written value only on the first 64 clock edges after reset is released. On later writes to address 2, those two bits keep their value while bits [7:2] take the written value.
- R3: A read of address 0 returns the counter's upper byte and a read of address 1 returns its lower byte. Read data is combinational from the address.
- R4: When the counter ticks from 0xFFFF to 0x0000, the wrap flag is set. The flag reads back as bit 7 of address 3, and the other bits of address 3 read as zero.
- R5: The interrupt output is high exactly while the wrap flag is set and control bit 7 is set.
- R6: A write to address 0 loads the upper byte and keeps the lower byte. A write to address 1 loads the lower byte and keeps the upper byte. A counter write replaces that cycle's tick.
- R7: Writing address 3 with bit 7 at 1 clears the wrap flag. Writing it with bit 7 at 0 leaves the flag unchanged.
- R8: When a wrap and a clear write fall in the same cycle, the flag ends up set.
- R9: Reset clears the counter, the control byte and the wrap flag, so the divider starts at divide by 1 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_addr | input | 2 | Register select: 0 counter upper byte, 1 counter lower byte, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ovf_irq | output | 1 | Wrap interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. The new counter byte, control byte or flag state can therefore be read one cycle later through the combinational read path. A wrap is seen on the status byte and on the interrupt line in the cycle after the edge where the counter rolls over. The bench keeps a reference model that it updates on the same edges. At each falling edge, before it drives the next stimulus, it compares the read data and the interrupt line against that model. Directed checks read back the literal values one cycle after each write, which matches these latencies.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int SEL_W = 2;
    localparam int DIV_W = 4;

    typedef enum logic [SEL_W-1:0] {
        DIV_BY_1  = 2'b00,
        DIV_BY_4  = 2'b01,
        DIV_BY_8  = 2'b10,
        DIV_BY_16 = 2'b11
    } div_sel_e;

    localparam logic [1:0] ADDR_CNT_HI = 2'd0;
    localparam logic [1:0] ADDR_CNT_LO = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_STAT   = 2'd3;

    // Terminal-phase mask: tick when the masked divider bits are all ones.
    function automatic logic [DIV_W-1:0] div_mask(div_sel_e sel);
        case (sel)
            DIV_BY_1:  return 4'b0000;
            DIV_BY_4:  return 4'b0011;
            DIV_BY_8:  return 4'b0111;
            default:   return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/frc_window.sv
module frc_window #(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic open_o
);
    localparam int CW = $clog2(WINDOW + 1);

    typedef struct packed {
        logic [CW-1:0] cyc;
    } win_state_t;

    win_state_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (win_q.cyc < CW'(WINDOW)) begin
            win_d.cyc = win_q.cyc + {{(CW-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign open_o = (win_q.cyc < CW'(WINDOW));

    // Once closed, the window stays closed until reset.
    assert_window_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !open_o |=> !open_o);

endmodule

// File: rtl/frc_prescale.sv
module frc_prescale
    import frc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_sel_e sel_i,
    output logic     tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_state_t;

    pre_state_t pre_d, pre_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = div_mask(sel_i);
        tick_o = ((pre_q.phase & mask) == mask);
        pre_d  = pre_q;
        pre_d.phase = pre_q.phase + {{(DIV_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  wr_hi_i,
    input  logic                  wr_lo_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    output logic [2*BYTE_W-1:0]   count_o,
    output logic                  wrap_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (wr_hi_i) begin
            cnt_d.cnt = {wdata_i, cnt_q.cnt[BYTE_W-1:0]};
        end else if (wr_lo_i) begin
            cnt_d.cnt = {cnt_q.cnt[CNT_W-1:BYTE_W], wdata_i};
        end else if (tick_i) begin
            cnt_d.cnt = cnt_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
            wrap_o    = (cnt_q.cnt == {CNT_W{1'b1}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q.cnt;

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_hi_i && !wr_lo_i) |=> (count_o == CNT_W'($past(count_o) + 1)));

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_hi_i && !wr_lo_i) |=> $stable(count_o));

    assert_keep_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_i |=> (count_o[BYTE_W-1:0] == $past(count_o[BYTE_W-1:0])));

    assert_keep_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wr_hi_i) |=> (count_o[CNT_W-1:BYTE_W] == $past(count_o[CNT_W-1:BYTE_W])));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_o == '0));

endmodule

// File: rtl/frc_regs.sv
module frc_regs
    import frc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_stat_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              win_open_i,
    input  logic              wrap_i,
    output logic [BYTE_W-1:0] ctrl_o,
    output div_sel_e          sel_o,
    output logic              ien_o,
    output logic              flag_o
);
    localparam int IEN_BIT  = BYTE_W - 1;
    localparam int FLAG_BIT = BYTE_W - 1;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic              flag;
    } reg_state_t;

    reg_state_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_ctrl_i) begin
            if (win_open_i) reg_d.ctrl = wdata_i;
            else            reg_d.ctrl = {wdata_i[BYTE_W-1:SEL_W], reg_q.ctrl[SEL_W-1:0]};
        end
        if (wrap_i) begin
            reg_d.flag = 1'b1;
        end else if (wr_stat_i && wdata_i[FLAG_BIT]) begin
            reg_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign ctrl_o = reg_q.ctrl;
    assign sel_o  = div_sel_e'(reg_q.ctrl[SEL_W-1:0]);
    assign ien_o  = reg_q.ctrl[IEN_BIT];
    assign flag_o = reg_q.flag;

    assert_sel_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open_i |=> $stable(ctrl_o[SEL_W-1:0]));

    assert_upper_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && !win_open_i) |=> (ctrl_o[BYTE_W-1:SEL_W] == $past(wdata_i[BYTE_W-1:SEL_W])));

    assert_set_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> flag_o);

    assert_clear_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat_i && wdata_i[FLAG_BIT] && !wrap_i) |=> !flag_o);

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(wr_stat_i && wdata_i[FLAG_BIT])) |=> flag_o);

endmodule

// File: rtl/frc_timer.sv
module frc_timer
    import frc_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WINDOW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              ovf_irq
);
    localparam int CNT_W = 2 * BYTE_W;

    logic              win_open;
    logic              tick;
    logic              wrap;
    logic [CNT_W-1:0]  count;
    logic [BYTE_W-1:0] ctrl;
    div_sel_e          sel;
    logic              ien;
    logic              flag;
    logic              wr_hi, wr_lo, wr_ctrl, wr_stat;

    always_comb begin
        wr_hi   = bus_wr && (bus_addr == ADDR_CNT_HI);
        wr_lo   = bus_wr && (bus_addr == ADDR_CNT_LO);
        wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
        wr_stat = bus_wr && (bus_addr == ADDR_STAT);
    end

    frc_window #(.WINDOW(WINDOW)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_o (win_open)
    );

    frc_prescale u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .tick_o (tick)
    );

    frc_counter #(.BYTE_W(BYTE_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_hi_i (wr_hi),
        .wr_lo_i (wr_lo),
        .wdata_i (bus_wdata),
        .count_o (count),
        .wrap_o  (wrap)
    );

    frc_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl_i  (wr_ctrl),
        .wr_stat_i  (wr_stat),
        .wdata_i    (bus_wdata),
        .win_open_i (win_open),
        .wrap_i     (wrap),
        .ctrl_o     (ctrl),
        .sel_o      (sel),
        .ien_o      (ien),
        .flag_o     (flag)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CNT_HI: bus_rdata = count[CNT_W-1:BYTE_W];
            ADDR_CNT_LO: bus_rdata = count[BYTE_W-1:0];
            ADDR_CTRL:   bus_rdata = ctrl;
            default:     bus_rdata = {flag, {(BYTE_W-1){1'b0}}};
        endcase
    end

    assign ovf_irq = flag && ien;

    assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ien && !wr_ctrl) |=> ovf_irq);

    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !flag) |=> !ovf_irq);

endmodule

// File: tb/sim_frc_timer.sv
module sim_frc_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ovf_irq;

    int checks = 0;
    int fails = 0;
    string cur_tag = "R9";

    // behavioural reference state
    int m_cnt, m_div, m_cyc, m_ctrl, m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    frc_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ovf_irq   (ovf_irq)
    );

    function automatic int mask_of(int s);
        case (s & 3)
            0: return 0;
            1: return 3;
            2: return 7;
            default: return 15;
        endcase
    endfunction

    function automatic int model_read(int a);
        case (a)
            0: return (m_cnt >> 8) & 255;
            1: return m_cnt & 255;
            2: return m_ctrl;
            default: return m_flag << 7;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int msk, nc, wd;
        bit ov;
        if (!rst_n) begin
            m_cnt <= 0; m_div <= 0; m_cyc <= 0; m_ctrl <= 0; m_flag <= 0;
        end else begin
            msk = mask_of(m_ctrl);
            wd  = int'(bus_wdata);
            nc  = m_cnt;
            ov  = 1'b0;
            if (bus_wr && bus_addr == 2'd0)      nc = (wd << 8) | (m_cnt & 255);
            else if (bus_wr && bus_addr == 2'd1) nc = (m_cnt & 16'hFF00) | wd;
            else if ((m_div & msk) == msk) begin
                ov = (m_cnt == 65535);
                nc = (m_cnt + 1) & 65535;
            end
            m_cnt <= nc;
            if (bus_wr && bus_addr == 2'd2)
                m_ctrl <= (m_cyc < 64) ? wd : ((wd & 252) | (m_ctrl & 3));
            if (ov) m_flag <= 1;
            else if (bus_wr && bus_addr == 2'd3 && wd[7]) m_flag <= 0;
            m_div <= (m_div + 1) & 15;
            if (m_cyc < 64) m_cyc <= m_cyc + 1;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        check(cur_tag, int'(bus_rdata), model_read(int'(bus_addr)));
        check("R5", int'(ovf_irq), (m_flag != 0 && (m_ctrl & 128) != 0) ? 1 : 0);
    endtask

    task automatic step(bit wr, int a, int d);
        @(negedge clk);
        compare();
        bus_wr    = wr;
        bus_addr  = 2'(a);
        bus_wdata = 8'(d);
    endtask

    task automatic idle(int n, int a);
        for (int i = 0; i < n; i++) step(1'b0, a, 0);
    endtask

    task automatic expect_now(string tag, int exp);
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : stim
        do_reset();
        // R9: reset values seen through every address
        cur_tag = "R9";
        step(1'b0, 2, 0); expect_now("R9", 0);
        step(1'b0, 3, 0); expect_now("R9", 0);
        check("R9", int'(ovf_irq), 0);
        idle(4, 1);

        // R1: divide by 4 chosen inside the window
        cur_tag = "R1";
        step(1'b1, 2, 8'h01);
        idle(40, 1);
        cur_tag = "R3";
        idle(10, 0);
        idle(10, 1);

        // R2: window now closed; select bits keep 01
        cur_tag = "R2";
        step(1'b1, 2, 8'hFE);
        step(1'b0, 2, 0); expect_now("R2", 8'hFD);

        // R6: byte writes keep the other byte
        cur_tag = "R6";
        step(1'b1, 0, 8'hFF);
        step(1'b1, 1, 8'hF0);
        step(1'b0, 0, 0); expect_now("R6", 8'hFF);
        step(1'b0, 1, 0); expect_now("R6", 8'hF0);

        // R4: wrap after 16 ticks of 4 cycles
        cur_tag = "R4";
        idle(90, 3);
        expect_now("R4", 8'h80);
        check("R5", int'(ovf_irq), 1);

        // R7: write 0 keeps, write 1 clears
        cur_tag = "R7";
        step(1'b1, 3, 8'h7F);
        step(1'b0, 3, 0); expect_now("R7", 8'h80);
        step(1'b1, 3, 8'h80);
        step(1'b0, 3, 0); expect_now("R7", 8'h00);
        check("R5", int'(ovf_irq), 0);

        // R8: clear request lands on the wrapping edge
        cur_tag = "R8";
        step(1'b1, 0, 8'hFF);
        step(1'b1, 1, 8'hFF);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            compare();
            if (m_cnt == 65535 && (m_div & mask_of(m_ctrl)) == mask_of(m_ctrl)) begin
                bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h80;
                break;
            end
            bus_wr = 1'b0; bus_addr = 2'd3;
        end
        step(1'b0, 3, 0); expect_now("R8", 8'h80);

        // R9: second reset restores divide by 1
        do_reset();
        cur_tag = "R9";
        step(1'b0, 2, 0); expect_now("R9", 0);
        cur_tag = "R1";
        idle(20, 1);
        step(1'b1, 2, 8'h03);
        idle(300, 1);
        idle(40, 0);
        cur_tag = "R2";
        step(1'b1, 2, 8'h00);
        step(1'b0, 2, 0); expect_now("R2", 8'h03);

        // mixed traffic with a reset in the middle
        cur_tag = "R3";
        for (int k = 0; k < 2; k++) begin
            do_reset();
            for (int i = 0; i < 1500; i++) begin
                int r;
                r = int'($urandom_range(0, 3));
                step(r == 0, int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
            end
        end
        step(1'b0, 0, 0);

        summary();
        $finish;
    end

endmodule